// File: doc/BRIEF.md
# TMDS Receive Symbol Boundary Aligner

This block finds the 10-bit symbol boundary on one TMDS lane. A deserializer delivers ten raw bits per clock, but the point in the serial stream where a symbol starts is unknown, so any of ten bit offsets may be the right one. The aligner joins the current raw word with the one before it into a 20-bit window and inspects all ten candidate 10-bit slices every cycle.

A slice counts as a control hit only if it has seven or more bit transitions and equals one of the four control-period codes. Pixel and data-island symbols never reach that transition count. A run of hits at a single offset locks the block to that offset. From then on it outputs slices taken at that offset as aligned symbols. If control symbols keep appearing at some other offset, the aligner gives up the lock and searches again.

Bit 0 of the raw word is the earliest bit received. Offset k is the slice starting at window bit k, where bits 9..0 of the window come from the previous raw word.

Top module: `tmds_symbol_aligner`

## Requirements
- R1: While reset is asserted and after it is released, with no control hits, `locked_o` is 0, `offset_o` is 0 and `sym_o` is 0.
- R2: A slice is a hit only if it has at least 7 transitions between adjacent bits and equals one of 0x354, 0x0AB, 0x154 or 0x2AB. These hex values are read with bit 0 as the earliest bit. A stream of symbols with five or fewer transitions never produces lock.
- R3: Eight hit cycles in a row at the same offset set `locked_o` on the following clock edge. `offset_o` then shows that offset, which equals the number of bits the stream is delayed relative to a word boundary, modulo 10.
- R4: A cycle with no hit restarts the run count. Seven hits, a gap, then seven more hits do not lock.
- R5: `sym_o` is the window slice at `offset_o`, registered once. While locked, each transmitted symbol appears unchanged on `sym_o`.
- R6: While locked, cycles without hits leave the lock and the mismatch count alone. A hit at the locked offset clears the mismatch count. Three mismatching control hits keep the lock and keep `offset_o`.
- R7: While locked, four control-hit cycles that show hits only at other offsets drop `locked_o`. Those four cycles need not be adjacent, as long as no hit at the locked offset falls between them. A later run of eight hits locks to the new offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock from the deserializer |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| raw_i | input | 10 | Raw deserialized bits, bit 0 earliest |
| sym_o | output | 10 | Symbol taken at the selected offset |
| locked_o | output | 1 | Boundary lock held |
| offset_o | output | 4 | Selected bit offset, 0 to 9 |

## Verification
The assertions take for granted that the input stream does not produce spurious control matches at offsets other than the true one. Otherwise a lock rise, a lock drop or a stable offset could come from accidental bit alignments. The stimulus keeps within this by using one control code per run and filler symbols made of five zeros followed by five ones. It also inserts slips only as runs of zero bits placed next to filler, so every seam between symbols contains either a triple zero or a triple one, and no control code contains either.

// File: rtl/tmds_align_pkg.sv
package tmds_align_pkg;

  localparam int unsigned SYM_W   = 10;
  localparam int unsigned WIN_W   = 2 * SYM_W;
  localparam int unsigned OFF_W   = $clog2(SYM_W);
  localparam int unsigned TRANS_W = $clog2(SYM_W);

  // Number of adjacent-bit changes inside one candidate slice.
  function automatic logic [TRANS_W-1:0] count_edges(input logic [SYM_W-1:0] s);
    logic [TRANS_W-1:0] cnt;
    cnt = '0;
    for (int i = 0; i < SYM_W - 1; i++) begin
      cnt = cnt + {{(TRANS_W-1){1'b0}}, s[i] ^ s[i+1]};
    end
    return cnt;
  endfunction

  // The four control-period codes, bit 0 earliest on the wire.
  function automatic logic is_ctrl_code(input logic [SYM_W-1:0] s);
    return (s == 10'h354) || (s == 10'h0AB) || (s == 10'h154) || (s == 10'h2AB);
  endfunction

endpackage

// File: rtl/tmds_reset_sync.sv
module tmds_reset_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/tmds_hit_detect.sv
module tmds_hit_detect
  import tmds_align_pkg::*;
#(
  parameter int unsigned MIN_TRANS = 7
) (
  input  logic [WIN_W-1:0] win_i,
  output logic [SYM_W-1:0] hit_o
);

  for (genvar k = 0; k < SYM_W; k++) begin : g_offset
    logic [SYM_W-1:0]   slice;
    logic [TRANS_W-1:0] edges;
    assign slice    = win_i[k +: SYM_W];
    assign edges    = count_edges(slice);
    assign hit_o[k] = (edges >= TRANS_W'(MIN_TRANS)) && is_ctrl_code(slice);
  end

endmodule

// File: rtl/tmds_lock_ctrl.sv
module tmds_lock_ctrl
  import tmds_align_pkg::*;
#(
  parameter int unsigned LOCK_RUN = 8,
  parameter int unsigned DROP_RUN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] hit_i,
  output logic             locked_o,
  output logic [OFF_W-1:0] sel_o
);

  localparam int unsigned RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int unsigned MISS_W = $clog2(DROP_RUN + 1);

  logic             locked_q, locked_d;
  logic [OFF_W-1:0] cand_q, cand_d;
  logic [OFF_W-1:0] sel_q, sel_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic [OFF_W-1:0] first_hit;
  logic             found;
  logic             any_hit;
  logic             sel_en;

  // Lowest offset that shows a hit this cycle.
  always_comb begin
    first_hit = '0;
    found     = 1'b0;
    for (int k = 0; k < SYM_W; k++) begin
      if (!found && hit_i[k]) begin
        first_hit = OFF_W'(k);
        found     = 1'b1;
      end
    end
  end

  assign any_hit = |hit_i;

  always_comb begin
    locked_d = locked_q;
    cand_d   = cand_q;
    sel_d    = sel_q;
    run_d    = run_q;
    miss_d   = miss_q;
    sel_en   = 1'b0;
    if (!locked_q) begin
      if (!any_hit) begin
        run_d = '0;
      end else if (hit_i[cand_q]) begin
        run_d = run_q + RUN_W'(1);
      end else begin
        cand_d = first_hit;
        run_d  = RUN_W'(1);
      end
      if (run_d == RUN_W'(LOCK_RUN)) begin
        locked_d = 1'b1;
        sel_d    = cand_d;
        sel_en   = 1'b1;
        run_d    = '0;
        miss_d   = '0;
      end
    end else begin
      if (any_hit) begin
        if (hit_i[sel_q]) begin
          miss_d = '0;
        end else begin
          miss_d = miss_q + MISS_W'(1);
        end
      end
      if (miss_d == MISS_W'(DROP_RUN)) begin
        locked_d = 1'b0;
        miss_d   = '0;
        run_d    = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      cand_q   <= '0;
      run_q    <= '0;
      miss_q   <= '0;
    end else begin
      locked_q <= locked_d;
      cand_q   <= cand_d;
      run_q    <= run_d;
      miss_q   <= miss_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign locked_o = locked_q;
  assign sel_o    = sel_q;

endmodule

// File: rtl/tmds_word_select.sv
module tmds_word_select
  import tmds_align_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIN_W-1:0] win_i,
  input  logic [OFF_W-1:0] sel_i,
  output logic [SYM_W-1:0] sym_o
);

  logic [SYM_W-1:0] sym_d, sym_q;

  always_comb begin
    sym_d = '0;
    for (int k = 0; k < SYM_W; k++) begin
      if (sel_i == OFF_W'(k)) begin
        sym_d = win_i[k +: SYM_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q <= '0;
    end else begin
      sym_q <= sym_d;
    end
  end

  assign sym_o = sym_q;

endmodule

// File: rtl/tmds_symbol_aligner.sv
module tmds_symbol_aligner
  import tmds_align_pkg::*;
#(
  parameter int unsigned MIN_TRANS = 7,
  parameter int unsigned LOCK_RUN  = 8,
  parameter int unsigned DROP_RUN  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] raw_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             locked_o,
  output logic [OFF_W-1:0] offset_o
);

  logic             rst_sync_n;
  logic [SYM_W-1:0] prev_q;
  logic [WIN_W-1:0] window;
  logic [SYM_W-1:0] hit_vec;

  tmds_reset_sync i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= raw_i;
    end
  end

  // Older word occupies the low half: window bit 0 is the earliest bit.
  assign window = {raw_i, prev_q};

  tmds_hit_detect #(
    .MIN_TRANS (MIN_TRANS)
  ) i_hit_detect (
    .win_i (window),
    .hit_o (hit_vec)
  );

  tmds_lock_ctrl #(
    .LOCK_RUN (LOCK_RUN),
    .DROP_RUN (DROP_RUN)
  ) i_lock_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .hit_i    (hit_vec),
    .locked_o (locked_o),
    .sel_o    (offset_o)
  );

  tmds_word_select i_word_select (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .win_i  (window),
    .sel_i  (offset_o),
    .sym_o  (sym_o)
  );

endmodule

// File: rtl/tmds_align_checker.sv
module tmds_align_checker
  import tmds_align_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SYM_W-1:0] hit_vec_i,
  input logic             locked_i,
  input logic [OFF_W-1:0] offset_i
);

  logic [SYM_W-1:0] hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= '0;
    end else begin
      hit_q <= hit_vec_i;
    end
  end

  // R3: lock only rises right after a hit at the offset it reports
  assert_lock_follows_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_i) |-> hit_q[offset_i]);

  // R3: the reported offset is always a real bit position
  assert_offset_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offset_i < OFF_W'(SYM_W));

  // R6: the offset does not move while lock is held
  assert_offset_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && $past(locked_i)) |-> $stable(offset_i));

  // R7: lock only drops on a cycle with hits, none at the locked offset
  assert_drop_on_mismatch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_i) |-> ((|hit_q) && !hit_q[offset_i]));

endmodule

bind tmds_symbol_aligner tmds_align_checker i_align_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hit_vec_i (hit_vec),
  .locked_i  (locked_o),
  .offset_i  (offset_o)
);

// File: tb/test_tmds_symbol_aligner.sv
module test_tmds_symbol_aligner;

  localparam logic [9:0] FILL   = 10'h3E0;
  localparam logic [9:0] MARKER = 10'h3F8;

  logic       clk;
  logic       rst_n;
  logic [9:0] raw;
  logic [9:0] sym;
  logic       locked;
  logic [3:0] offset;

  int checks = 0;
  int errors = 0;

  logic [9:0] bbuf;
  int         bcnt;
  logic       watch_en;
  logic       seen;

  tmds_symbol_aligner i_tmds_symbol_aligner (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .raw_i    (raw),
    .sym_o    (sym),
    .locked_o (locked),
    .offset_o (offset)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [9:0] w);
    @(negedge clk);
    if (watch_en && locked && (sym == MARKER)) seen = 1'b1;
    raw = w;
  endtask

  task automatic push_bits(input logic [9:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      bbuf[bcnt] = v[i];
      bcnt++;
      if (bcnt == 10) begin
        send_word(bbuf);
        bcnt = 0;
      end
    end
  endtask

  task automatic push_fill(input int n);
    for (int i = 0; i < n; i++) push_bits(FILL, 10);
  endtask

  task automatic push_ctrl(input logic [9:0] code, input int n);
    for (int i = 0; i < n; i++) push_bits(code, 10);
  endtask

  task automatic apply_reset();
    rst_n    = 1'b0;
    raw      = '0;
    bcnt     = 0;
    bbuf     = '0;
    watch_en = 1'b0;
    seen     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic lock_at(input int s, input logic [9:0] code);
    apply_reset();
    push_fill(4);
    push_bits(10'h000, s);
    push_fill(2);
    push_ctrl(code, 8);
    push_fill(3);
  endtask

  task automatic check_marker(input string tag);
    seen     = 1'b0;
    watch_en = 1'b1;
    push_bits(MARKER, 10);
    push_fill(3);
    watch_en = 1'b0;
    check(seen, tag, int'(seen), 1);
  endtask

  task automatic t_reset();
    apply_reset();
    check(locked == 1'b0, "R1 locked after reset", int'(locked), 0);
    check(offset == 4'd0, "R1 offset after reset", int'(offset), 0);
    check(sym == 10'd0,   "R1 symbol after reset", int'(sym), 0);
  endtask

  task automatic t_data_only();
    apply_reset();
    push_fill(40);
    check(locked == 1'b0, "R2 no lock on data symbols", int'(locked), 0);
  endtask

  task automatic t_short_runs();
    apply_reset();
    push_fill(4);
    push_bits(10'h000, 4);
    push_fill(2);
    push_ctrl(10'h354, 7);
    push_fill(3);
    push_ctrl(10'h354, 7);
    push_fill(3);
    check(locked == 1'b0, "R4 two runs of seven", int'(locked), 0);
  endtask

  task automatic t_lock(input int s, input logic [9:0] code);
    lock_at(s, code);
    check(locked == 1'b1, "R3 lock after eight hits", int'(locked), 1);
    check(offset == 4'(s), "R3 offset equals slip", int'(offset), s);
    check_marker("R5 aligned symbol output");
  endtask

  task automatic t_mismatch();
    lock_at(2, 10'h354);
    // move the stream to offset 7 and send three control symbols
    push_bits(10'h000, 5);
    push_fill(1);
    push_ctrl(10'h354, 3);
    push_fill(3);
    check(locked == 1'b1, "R6 three mismatches keep lock", int'(locked), 1);
    check(offset == 4'd2, "R6 offset held", int'(offset), 2);
    // back to offset 2: one hit there clears the mismatch count
    push_bits(10'h000, 5);
    push_fill(1);
    push_ctrl(10'h354, 1);
    push_fill(1);
    push_bits(10'h000, 5);
    push_fill(1);
    push_ctrl(10'h354, 3);
    push_fill(3);
    check(locked == 1'b1, "R6 match resets mismatch count", int'(locked), 1);
    check(offset == 4'd2, "R6 offset still held", int'(offset), 2);
    // one more mismatch after a data gap makes four
    push_ctrl(10'h354, 1);
    push_fill(3);
    check(locked == 1'b0, "R7 lock dropped", int'(locked), 0);
    push_ctrl(10'h354, 8);
    push_fill(3);
    check(locked == 1'b1, "R7 relock", int'(locked), 1);
    check(offset == 4'd7, "R7 new offset", int'(offset), 7);
    check_marker("R5 output after relock");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    raw   = '0;
    t_reset();
    t_data_only();
    t_short_runs();
    t_lock(0, 10'h354);
    t_lock(3, 10'h154);
    t_lock(9, 10'h0AB);
    t_lock(6, 10'h2AB);
    t_mismatch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule